// File: doc/BRIEF.md
# Infrared Carrier and Timer Tick Generator

This block produces the modulated carrier that drives an infrared transmitter LED, together with a prescaled one-clock timer enable. Both outputs are derived from the single system clock and are governed by one 8-bit control register that a host writes through a simple write-enable port. The stored register value is always visible on `ctrl_q`.

The low two bits of the register pick one of four carrier shapes, three with a 50 % duty and one with a 33 % duty. One bit parks the carrier at a steady high level. Another bit doubles every carrier period and, in the same step, switches the timer tick from every 64 clocks to every 128 clocks. Three bits form a data-pointer extension that is only stored and presented on `dptr_o`. A carrier setting changes only at a period boundary, so the LED never sees a clipped pulse.

Top module: `ir_carrier_gen`

## Requirements
- R1: While reset is held and directly after it, `ctrl_q` reads 8'h03, `dptr_o` reads 0, `carrier_o` is high and `tick_o` is low.
- R2: A clock edge with `wr_en` high stores `{1'b0, wr_data[6:0]}` into the register; without `wr_en` the register keeps its value.
- R3: Register bit 7 always reads 0; writing a 1 to it has no effect (writing 8'hFF reads back 8'h7F).
- R4: Register bits [6:4] appear on `dptr_o` and change neither the carrier nor the tick.
- R5: With bit 3 = 0 and bit 2 = 0, bits [1:0] = 00/01/10/11 give a carrier period of 8/64/96/96 clocks with a high time of 4/32/48/32 clocks; every period starts with its high part.
- R6: With bit 3 = 1 and bit 2 = 0, the same four codes give periods of 16/128/192/192 clocks with high times of 8/64/96/64 clocks.
- R7: With bit 2 = 1, once the running period ends, `carrier_o` stays high whatever bits [1:0] and bit 3 hold.
- R8: A new carrier setting (bits [3:0]) is applied only at the next period boundary: the period in progress finishes with its old high and low times, and a write landing in any cycle up to and including the period's last cycle governs the following period.
- R9: `tick_o` is a one-clock pulse repeated every 64 clocks when bit 3 = 0 and every 128 clocks when bit 3 = 1.
- R10: A write that changes bit 3 restarts the tick count; the first pulse of the new rate is high N+1 clocks after the write edge (N = 64 or 128), with no pulse in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| ctrl_q | output | 8 | Current register contents |
| dptr_o | output | 3 | Stored data-pointer extension bits |
| carrier_o | output | 1 | Modulated carrier to the transmitter |
| tick_o | output | 1 | One-clock timer enable pulse |

## Verification
The register write and the carrier period boundary can fall on the same clock, and the question is then whether the running period or the next one takes the new setting. The bench writes a new mode at several offsets inside a running 64-clock period, including the offset whose write edge lands in the period's final cycle, and judges each case by measuring that the interrupted period still has 32 high and 64 total clocks while the next one has the new shape. A bit-3 write can likewise coincide with a tick; it is judged by the exact distance from the write to the first tick of the new rate.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

  // Carrier-related fields of the control register, in register bit order [3:0]
  typedef struct packed {
    logic       half;   // bit 3: double carrier period and tick interval
    logic       off;    // bit 2: carrier parked high
    logic [1:0] mode;   // bits 1:0: divide ratio and duty
  } car_cfg_t;

  localparam logic [7:0] CTRL_RST = 8'b0000_0011;

endpackage

// File: rtl/ir_rst_sync.sv
module ir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ir_ctrl_reg.sv
module ir_ctrl_reg
  import ir_carrier_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_q,
  output car_cfg_t   cfg_o,
  output logic [2:0] dptr_o
);

  logic [7:0] ctrl_d;

  // Bit 7 is not storable: it is forced to zero on every write.
  always_comb begin
    ctrl_d = {1'b0, wr_data[6:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctrl_q <= CTRL_RST;
    else if (wr_en) ctrl_q <= ctrl_d;
  end

  assign cfg_o  = car_cfg_t'(ctrl_q[3:0]);
  assign dptr_o = ctrl_q[6:4];

endmodule

// File: rtl/ir_carrier_div.sv
module ir_carrier_div
  import ir_carrier_pkg::*;
#(
  parameter int DIV0       = 8,
  parameter int DIV1       = 64,
  parameter int DIV2       = 96,
  parameter int DIV3       = 96,
  parameter int THIRD_MODE = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  car_cfg_t cfg_i,
  output car_cfg_t act_o,
  output logic     wrap_o,
  output logic     carrier_o
);

  localparam int MAX01   = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int MAX23   = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int MAX_DIV = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CNT_W   = $clog2(2 * MAX_DIV);

  function automatic int base_f(logic [1:0] m);
    case (m)
      2'd0:    return DIV0;
      2'd1:    return DIV1;
      2'd2:    return DIV2;
      default: return DIV3;
    endcase
  endfunction

  function automatic int period_f(car_cfg_t c);
    return c.half ? 2 * base_f(c.mode) : base_f(c.mode);
  endfunction

  function automatic logic [CNT_W-1:0] last_f(car_cfg_t c);
    return CNT_W'(period_f(c) - 1);
  endfunction

  function automatic logic [CNT_W-1:0] high_f(car_cfg_t c);
    int p;
    p = period_f(c);
    return (int'(c.mode) == THIRD_MODE) ? CNT_W'(p / 3) : CNT_W'(p / 2);
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d;
  car_cfg_t         act_q, act_d;
  logic             car_q, car_d;
  logic             wrap;

  // Next state: the live setting is swapped only on the wrap cycle.
  always_comb begin
    wrap  = (cnt_q == last_f(act_q));
    act_d = wrap ? cfg_i : act_q;
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    car_d = act_d.off | (cnt_d < high_f(act_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= car_cfg_t'(CTRL_RST[3:0]);
      car_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      car_q <= car_d;
    end
  end

  assign act_o     = act_q;
  assign wrap_o    = wrap;
  assign carrier_o = car_q;

endmodule

// File: rtl/ir_tick_div.sv
module ir_tick_div
  import ir_carrier_pkg::*;
#(
  parameter int TICK_BASE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_i,
  output logic tick_o
);

  localparam int CNT_W = $clog2(2 * TICK_BASE);

  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             half_q;
  logic             tick_q, tick_d;
  logic             restart;

  always_comb begin
    restart = half_i ^ half_q;
    last    = half_q ? CNT_W'(2 * TICK_BASE - 1) : CNT_W'(TICK_BASE - 1);
    cnt_d   = (restart || (cnt_q == last)) ? '0 : cnt_q + 1'b1;
    tick_d  = !restart && (cnt_q == last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= CTRL_RST[3];
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_i;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_carrier_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV0        = 8,
  parameter int DIV1        = 64,
  parameter int DIV2        = 96,
  parameter int DIV3        = 96,
  parameter int THIRD_MODE  = 3,
  parameter int TICK_BASE   = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_q,
  output logic [2:0] dptr_o,
  output logic       carrier_o,
  output logic       tick_o
);

  logic     rst_sync_n;
  car_cfg_t cfg;
  car_cfg_t car_act;
  logic     car_wrap;

  ir_rst_sync #(.STAGES(SYNC_STAGES)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ir_ctrl_reg reg_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .cfg_o   (cfg),
    .dptr_o  (dptr_o)
  );

  ir_carrier_div #(
    .DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3), .THIRD_MODE(THIRD_MODE)
  ) car_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_i     (cfg),
    .act_o     (car_act),
    .wrap_o    (car_wrap),
    .carrier_o (carrier_o)
  );

  ir_tick_div #(.TICK_BASE(TICK_BASE)) tick_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .half_i (cfg.half),
    .tick_o (tick_o)
  );

endmodule

// File: rtl/ir_carrier_gen_chk.sv
module ir_carrier_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] ctrl_q,
  input logic [2:0] dptr_o,
  input logic       carrier_o,
  input logic       tick_o,
  input logic [3:0] act_cfg,
  input logic       wrap
);

  p_bit7_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] == 1'b0);

  p_dptr_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dptr_o == ctrl_q[6:4]);

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q == {1'b0, $past(wr_data[6:0])}));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));

  p_boundary_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_cfg));

  p_off_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_cfg[2] |-> carrier_o);

  p_tick_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

bind ir_carrier_gen ir_carrier_gen_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .ctrl_q    (ctrl_q),
  .dptr_o    (dptr_o),
  .carrier_o (carrier_o),
  .tick_o    (tick_o),
  .act_cfg   (car_act),
  .wrap      (car_wrap)
);

// File: tb/ir_carrier_gen_tb_top.sv
`timescale 1ns/1ps
module ir_carrier_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] ctrl_q;
  logic [2:0] dptr_o;
  logic       carrier_o;
  logic       tick_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ir_carrier_gen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ctrl_q    (ctrl_q),
    .dptr_o    (dptr_o),
    .carrier_o (carrier_o),
    .tick_o    (tick_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic sync_rise();
    logic prev;
    prev = carrier_o;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (carrier_o && !prev) return;
      prev = carrier_o;
    end
    chk("sync rise timeout", 0, 1);
  endtask

  // Called on the sample right after a rise; returns on the next rise.
  task automatic measure(input int k, input logic [7:0] d, output int h, output int p);
    logic prev;
    h = 1; p = 1; prev = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (carrier_o && !prev) return;
      prev = carrier_o;
      p++;
      if (carrier_o) h++;
      if (p == k) begin
        wr_en   = 1'b1;
        wr_data = d;
      end
    end
  endtask

  function automatic int exp_period(int half, int mode);
    int b;
    b = (mode == 0) ? 8 : (mode == 1) ? 64 : 96;
    return half ? 2 * b : b;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ctrl_q at reset", ctrl_q, 8'h03);
    chk("R1 dptr_o at reset", dptr_o, 0);
    chk("R1 carrier_o at reset", carrier_o, 1);
    chk("R1 tick_o at reset", tick_o, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_fields();
    wr(8'hFF);
    chk("R3 bit7 ignored", ctrl_q, 8'h7F);
    chk("R4 dptr_o all ones", dptr_o, 7);
    wr(8'hA5);
    chk("R2 write readback", ctrl_q, 8'h25);
    chk("R4 dptr_o pattern", dptr_o, 2);
    repeat (5) @(negedge clk);
    chk("R2 value held", ctrl_q, 8'h25);
  endtask

  task automatic t_carrier(input int half, input int mode);
    logic [7:0] d;
    int h, p, ep, eh;
    d = {1'b0, 3'(mode * 2 + half + 1), 1'(half), 1'b0, 2'(mode)};
    wr(d);
    chk("R2 setting readback", ctrl_q, int'(d));
    chk("R4 dptr_o mirrors bits 6:4", dptr_o, int'(d[6:4]));
    repeat (400) @(negedge clk);
    sync_rise();
    measure(0, 8'h00, h, p);
    ep = exp_period(half, mode);
    eh = (mode == 3) ? ep / 3 : ep / 2;
    if (half != 0) begin
      chk($sformatf("R6 period mode %0d", mode), p, ep);
      chk($sformatf("R6 high time mode %0d", mode), h, eh);
    end else begin
      chk($sformatf("R5 period mode %0d", mode), p, ep);
      chk($sformatf("R5 high time mode %0d", mode), h, eh);
    end
  endtask

  task automatic t_off(input logic [7:0] d);
    int lows;
    wr(d);
    repeat (400) @(negedge clk);
    lows = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!carrier_o) lows++;
    end
    chk("R7 carrier parked high, low samples", lows, 0);
  endtask

  task automatic t_midwrite(input int k);
    int h, p;
    wr(8'h01);
    repeat (400) @(negedge clk);
    sync_rise();
    measure(k, 8'h00, h, p);
    chk($sformatf("R8 old period kept, write at %0d", k), p, 64);
    chk($sformatf("R8 old high kept, write at %0d", k), h, 32);
    measure(0, 8'h00, h, p);
    chk($sformatf("R8 next period new, write at %0d", k), p, 8);
    chk($sformatf("R8 next high new, write at %0d", k), h, 4);
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (tick_o) return;
    end
    chk("R9 tick timeout", 0, 1);
  endtask

  task automatic t_tick(input int half);
    int n, n_hi;
    wait_tick();
    for (int g = 0; g < 2; g++) begin
      n = 0; n_hi = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        n++;
        if (tick_o) break;
      end
      chk($sformatf("R9 tick spacing half=%0d", half), n, half ? 128 : 64);
      @(negedge clk);
      chk("R9 tick one clock wide", tick_o, 0);
      wait_tick();
    end
  endtask

  task automatic t_restart(input logic [7:0] d, input int nexp);
    int n;
    wr(d);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      n++;
      if (tick_o) break;
    end
    chk("R10 first tick after bit-3 change", n, nexp + 1);
  endtask

  initial begin
    #(150000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_fields();
    for (int hf = 0; hf < 2; hf++)
      for (int m = 0; m < 4; m++)
        t_carrier(hf, m);
    t_off(8'h04);
    t_off(8'h0C);
    t_midwrite(2);
    t_midwrite(40);
    t_midwrite(63);
    wr(8'h01);
    t_tick(0);
    t_restart(8'h09, 128);
    t_tick(1);
    t_restart(8'h71, 64);
    t_tick(0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule